// File: doc/BRIEF.md
# Free-Running Count-Up Timer

This block is a free-running count-up timer that software reaches through a small byte-addressed register window. A tick-enable input marks each 27 MHz oscillator period. The timer advances either on every such tick, or on every 27th tick through an internal prescaler, which gives a 1 MHz time base. When the counter's top bit falls from 1 to 0, a sticky rollover flag is raised. If interrupts are enabled, that flag drives a level interrupt output. Software clears the flag by writing a one to it.

A low-power control bit lets the timer stop counting while the suspend-acknowledge input (active low) is asserted. The hardware clears this bit by itself on the cycle that suspend ends. All register traffic uses a synchronous byte-wide read/write strobe pair. Read data is registered and appears one cycle after the read strobe. The counter width and the prescale ratio are parameters, which default to 32 bits and 27.

Top module: `upcount_timer`

## Requirements
- R1: After synchronous reset, the count is 0, the rollover flag is 0, the configuration byte is 00h, rdata is 00h and irq is low.
- R2: Byte offsets 8h, 9h, Ah and Bh return count bits 7:0, 15:8, 23:16 and 31:24. Bits above the counter width read as 0. Writes to these offsets have no effect on the count.
- R3: Status offset Ch bit 0 is the rollover flag. It sets on the clock edge where count bit CNT_W-1 goes from 1 to 0. Writing Ch with data bit 0 = 1 clears it. Writing with data bit 0 = 0 leaves it unchanged. A rollover in the same cycle as a clearing write leaves the flag set. Bits 7:1 read 0.
- R4: Configuration offset Dh reads back as {5'b0, pd, sel, ien}, with ien at bit 0, sel at bit 1 and pd at bit 2. Bits 7:3 ignore writes and read 0. All other offsets read 00h.
- R5: With sel = 1, the count advances by exactly one on each cycle where osc_tick is high.
- R6: With sel = 0, the count advances once for every PRESC_DIV osc_tick cycles. The prescaler restarts whenever sel changes, so the first slow step after a change needs a full PRESC_DIV ticks.
- R7: With pd = 1 and susp_n low, the count holds. With pd = 0, susp_n has no effect on counting.
- R8: On the cycle where susp_n rises from 0 to 1, pd is cleared. This clear wins over a simultaneous write of pd.
- R9: irq is a level output equal to ien AND the rollover flag.
- R10: rdata loads the addressed byte on the clock edge where rd_en is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| osc_tick | input | 1 | One-cycle enable per 27 MHz oscillator period |
| susp_n | input | 1 | Suspend acknowledge, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt: enable AND rollover flag |

## Verification
The hardest event to reach is the rollover flag setting, because a full-width counter needs billions of ticks to wrap. For that reason the bench builds the timer with a 10-bit counter. Under that parameter the same falling-top-bit logic fires about every thousand fast ticks. The bench runs long stretches of fast counting so the flag, the interrupt and the clearing writes all occur several times. Some of those wraps land beside random writes to the status offset, and some fall during suspend gating and prescaler restarts caused by random configuration writes.

// File: rtl/upt_pkg.sv
package upt_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CNT_B0 = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_CNT_B1 = 4'h9;
    localparam logic [ADDR_W-1:0] OFS_CNT_B2 = 4'hA;
    localparam logic [ADDR_W-1:0] OFS_CNT_B3 = 4'hB;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 4'hC;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 4'hD;

    // configuration byte, bit 2 down to bit 0
    typedef struct packed {
        logic pd;   // gate counting while suspended
        logic sel;  // 1: every tick, 0: prescaled
        logic ien;  // interrupt enable
    } cfg_t;

    function automatic logic [7:0] pick_byte(input logic [31:0] v, input logic [1:0] idx);
        return v[idx*8 +: 8];
    endfunction

endpackage

// File: rtl/upt_prescale.sv
module upt_prescale #(
    parameter int DIV = 27
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic sel,
    output logic step
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt;
    logic          sel_q;
    logic          chg;
    logic          term;

    assign chg  = sel ^ sel_q;
    assign term = (pcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt  <= '0;
            sel_q <= 1'b0;
        end else begin
            sel_q <= sel;
            if (chg)
                pcnt <= '0;
            else if (tick)
                pcnt <= term ? '0 : pcnt + 1'b1;
        end
    end

    assign step = sel ? tick : (tick && term && !chg);

    assert_presc_range_R6: assert property (@(posedge clk) disable iff (rst)
        pcnt <= LAST);

    assert_presc_restart_R6: assert property (@(posedge clk) disable iff (rst)
        chg |=> (pcnt == '0) || (pcnt == PW'(1)));

endmodule

// File: rtl/upt_counter.sv
module upt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign wrap = inc && (&cnt);

    assert_step_by_one_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/upt_regs.sv
module upt_regs
    import upt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [31:0]       cnt32,
    input  logic              wrap,
    input  logic              susp_n,
    output logic [7:0]        rdata,
    output cfg_t              cfg,
    output logic              flag
);
    logic susp_q;
    logic susp_rise;
    logic clr_req;
    cfg_t cfg_nxt;
    logic [7:0] rd_mux;

    assign susp_rise = susp_n && !susp_q;
    assign clr_req   = wr_en && (addr == OFS_STAT) && wdata[0];

    always_comb begin
        cfg_nxt = cfg;
        if (wr_en && addr == OFS_CFG)
            cfg_nxt = cfg_t'(wdata[2:0]);
        if (susp_rise)
            cfg_nxt.pd = 1'b0;
    end

    always_comb begin
        case (addr)
            OFS_CNT_B0, OFS_CNT_B1,
            OFS_CNT_B2, OFS_CNT_B3: rd_mux = pick_byte(cnt32, addr[1:0]);
            OFS_STAT:               rd_mux = {7'b0, flag};
            OFS_CFG:                rd_mux = {5'b0, cfg};
            default:                rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            susp_q <= 1'b1;
            cfg    <= '0;
            flag   <= 1'b0;
            rdata  <= 8'h00;
        end else begin
            susp_q <= susp_n;
            cfg    <= cfg_nxt;
            if (wrap)
                flag <= 1'b1;
            else if (clr_req)
                flag <= 1'b0;
            if (rd_en)
                rdata <= rd_mux;
        end
    end

    assert_pd_autoclear_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(susp_n) |=> !cfg.pd);

    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !wrap) |=> !flag);

    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req) |=> flag);

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/upcount_timer.sv
module upcount_timer
    import upt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PRESC_DIV = 27
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        osc_tick,
    input  logic        susp_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [3:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        irq
);
    cfg_t             cfg;
    logic             flag;
    logic             step;
    logic             cnt_inc;
    logic             wrap;
    logic [CNT_W-1:0] cnt;
    logic [31:0]      cnt32;

    upt_prescale #(.DIV(PRESC_DIV)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (osc_tick),
        .sel  (cfg.sel),
        .step (step)
    );

    assign cnt_inc = step && !(cfg.pd && !susp_n);

    upt_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (cnt_inc),
        .cnt  (cnt),
        .wrap (wrap)
    );

    assign cnt32 = 32'(cnt);

    upt_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .cnt32  (cnt32),
        .wrap   (wrap),
        .susp_n (susp_n),
        .rdata  (rdata),
        .cfg    (cfg),
        .flag   (flag)
    );

    assign irq = cfg.ien & flag;

    assert_flag_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(cnt[CNT_W-1]) |-> flag);

    assert_suspend_halt_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg.pd && !susp_n) |=> $stable(cnt));

    assert_no_tick_no_step_R5: assert property (@(posedge clk) disable iff (rst)
        !osc_tick |=> $stable(cnt));

endmodule

// File: tb/tb_upcount_timer.sv
module tb_upcount_timer;
    localparam int CLK_PERIOD = 10;
    localparam int TW         = 10;
    localparam int DIV        = 27;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic       susp_n = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    upcount_timer #(.CNT_W(TW), .PRESC_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .susp_n(susp_n),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    // reference model built from the requirements
    logic [TW-1:0] m_cnt;
    int            m_pres;
    logic          m_selq;
    logic          m_flag;
    logic [2:0]    m_cfg;
    logic          m_suspq;
    logic [7:0]    m_rdata;

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        logic [31:0] c32;
        c32 = 32'(m_cnt);
        case (a)
            4'h8: return c32[7:0];
            4'h9: return c32[15:8];
            4'hA: return c32[23:16];
            4'hB: return c32[31:24];
            4'hC: return {7'b0, m_flag};
            4'hD: return {5'b0, m_cfg};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic chg, stp, en, wrp;
        logic [2:0] nc;
        if (rst) begin
            m_cnt <= '0; m_pres <= 0; m_selq <= 1'b0; m_flag <= 1'b0;
            m_cfg <= 3'b0; m_suspq <= 1'b1; m_rdata <= 8'h00;
        end else begin
            chg = (m_cfg[1] != m_selq);
            stp = m_cfg[1] ? osc_tick : (osc_tick && m_pres == DIV-1 && !chg);
            en  = stp && !(m_cfg[2] && !susp_n);
            wrp = en && (&m_cnt);
            if (rd_en) m_rdata <= exp_read(addr);
            m_cnt <= m_cnt + TW'(en);
            if (chg) m_pres <= 0;
            else if (osc_tick) m_pres <= (m_pres == DIV-1) ? 0 : m_pres + 1;
            m_selq <= m_cfg[1];
            if (wrp) m_flag <= 1'b1;
            else if (wr_en && addr == 4'hC && wdata[0]) m_flag <= 1'b0;
            nc = m_cfg;
            if (wr_en && addr == 4'hD) nc = wdata[2:0];
            if (susp_n && !m_suspq) nc[2] = 1'b0;
            m_cfg   <= nc;
            m_suspq <= susp_n;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, compare at the following negedge
    task automatic cyc(input logic w, input logic r, input logic [3:0] a,
                       input logic [7:0] d, input logic tk, input logic sn,
                       input string tag);
        wr_en = w; rd_en = r; addr = a; wdata = d; osc_tick = tk; susp_n = sn;
        @(posedge clk);
        @(negedge clk);
        check(r ? tag : "R10", rdata, m_rdata);
        check("R9", {7'b0, irq}, {7'b0, m_cfg[0] & m_flag});
    endtask

    function automatic string tag_of(input logic [3:0] a);
        if (a >= 4'h8 && a <= 4'hB) return "R2";
        if (a == 4'hC) return "R3";
        return "R4";
    endfunction

    initial begin
        logic sn;
        void'($urandom(32'd20240611));
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        check("R1", {7'b0, irq}, 8'h00);
        check("R1", rdata, 8'h00);
        cyc(0, 1, 4'h8, 8'h00, 0, 1, "R1");
        cyc(0, 1, 4'hC, 8'h00, 0, 1, "R1");
        cyc(0, 1, 4'hD, 8'h00, 0, 1, "R1");
        cyc(0, 1, 4'h3, 8'h00, 0, 1, "R4");
        // R4: reserved config bits
        cyc(1, 0, 4'hD, 8'hFA, 0, 1, "R4");
        cyc(0, 1, 4'hD, 8'h00, 0, 1, "R4");
        // R5: fast counting
        cyc(1, 0, 4'hD, 8'h02, 0, 1, "R5");
        for (int i = 0; i < 20; i++) cyc(0, 1, 4'h8, 8'h00, 1, 1, "R5");
        // R6: prescaled counting, restart on select change
        cyc(1, 0, 4'hD, 8'h00, 1, 1, "R6");
        for (int i = 0; i < 70; i++) cyc(0, 1, 4'h8, 8'h00, 1, 1, "R6");
        // R2: count bytes are read-only
        cyc(1, 0, 4'h8, 8'h55, 1, 1, "R2");
        cyc(1, 0, 4'h9, 8'hFF, 1, 1, "R2");
        cyc(0, 1, 4'h8, 8'h00, 0, 1, "R2");
        cyc(0, 1, 4'h9, 8'h00, 0, 1, "R2");
        cyc(0, 1, 4'hB, 8'h00, 0, 1, "R2");
        // R7: suspend gating with pd set
        cyc(1, 0, 4'hD, 8'h06, 1, 1, "R7");
        for (int i = 0; i < 10; i++) cyc(0, 1, 4'h8, 8'h00, 1, 0, "R7");
        // R8: pd self-clears when suspend ends
        cyc(0, 1, 4'hD, 8'h00, 1, 0, "R8");
        cyc(0, 0, 4'hD, 8'h00, 1, 1, "R8");
        cyc(0, 1, 4'hD, 8'h00, 1, 1, "R8");
        // R7: pd clear means suspend ignored
        cyc(1, 0, 4'hD, 8'h02, 1, 0, "R7");
        for (int i = 0; i < 8; i++) cyc(0, 1, 4'h8, 8'h00, 1, 0, "R7");
        // R3 / R9: rollover with interrupt enabled
        cyc(1, 0, 4'hD, 8'h03, 1, 1, "R3");
        for (int i = 0; i < 1100; i++)
            cyc(0, (i % 50) == 0, 4'hC, 8'h00, 1, 1, "R3");
        cyc(1, 0, 4'hC, 8'hFE, 0, 1, "R3");
        cyc(0, 1, 4'hC, 8'h00, 0, 1, "R3");
        cyc(1, 0, 4'hC, 8'h01, 0, 1, "R3");
        cyc(0, 1, 4'hC, 8'h00, 0, 1, "R3");
        // random phase
        sn = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            logic w, r;
            logic [3:0] a;
            logic [7:0] d;
            w = ($urandom % 10) == 0;
            r = ($urandom % 3) == 0;
            a = 4'($urandom % 16);
            if (w && ($urandom % 2) == 0) a = 4'hD;
            d = 8'($urandom);
            if (w && a == 4'hD && ($urandom % 3) != 0) d[1] = 1'b1;
            if (($urandom % 60) == 0) sn = ~sn;
            cyc(w, r, a, d, ($urandom % 4) != 0, sn, tag_of(a));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule